// File: doc/BRIEF.md
# Scalar Floating-Point Min/Max Unit

This execution unit compares two floating-point operands and returns the larger or the smaller of them. Each operand is the low element of its own 128-bit vector register view. A 2-bit type field chooses the element precision: half, single or double. A 2-bit operation field chooses the mode: plain maximum or minimum, or the number-preferring variants, which pass a numeric operand through when the other one is a quiet NaN.

The chosen value lands in the lowest element of a 128-bit result. Above that element, the result holds either the first source register or zeros, as the merge input selects. An operation whose operands include a signalling NaN is an invalid operation. Depending on a control input, it either sets a sticky status flag or raises a one-cycle trap request. A reserved or disabled type encoding reports undefined and produces no result.

Top module: `fpmm_unit`

## Requirements
- R1: The type field selects the precision. 00 is single (32-bit), 01 is double (64-bit) and 11 is half (16-bit). Half is accepted only while half_en_i is 1. With half_en_i at 0, type 11 is undefined.
- R2: Type 10 is always undefined. An undefined request gives undef_o=1, result_o all zero, invalid_o=0 and no trap request, and it leaves the sticky flag unchanged.
- R3: The op field selects the mode: 00 maximum, 01 minimum, 10 number-preferring maximum, 11 number-preferring minimum.
- R4: Operands that are not NaN are ordered by sign and magnitude. -inf is the lowest value and +inf the highest. +0 counts as larger than -0.
- R5: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit is 1 and signalling when that bit is 0. In modes 00 and 01, any NaN operand gives the default NaN: sign 0, exponent all ones, top fraction bit 1, all other fraction bits 0. A signalling NaN operand also sets invalid_o.
- R6: In modes 10 and 11, if exactly one operand is a quiet NaN, the result is the other operand. Two quiet NaNs give the default NaN. Any signalling NaN gives the default NaN with invalid_o=1.
- R7: The computed value occupies the low esize bits of result_o. With merge_i=1, bits from esize up to 127 equal src1_i. With merge_i=0, those bits are zero.
- R8: With trap_en_i=1, an invalid operation pulses trap_req_o and leaves sticky_invalid_o unchanged. With trap_en_i=0, it sets sticky_invalid_o, which then stays set until reset.
- R9: The unit has one cycle of latency. A request accepted with valid_i at a clock edge is shown with valid_o=1 after that edge. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| type_i | input | 2 | Precision select |
| op_i | input | 2 | Mode select |
| merge_i | input | 1 | Keep upper bits of first source when 1 |
| half_en_i | input | 1 | Half precision support enabled |
| trap_en_i | input | 1 | Invalid raises trap instead of sticky flag |
| src1_i | input | 128 | First source register view |
| src2_i | input | 128 | Second source register view |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Destination register value |
| invalid_o | output | 1 | Invalid operation for this result |
| undef_o | output | 1 | Undefined encoding for this result |
| trap_req_o | output | 1 | Trap request pulse |
| sticky_invalid_o | output | 1 | Sticky invalid status |

## Verification
NaN handling and the merge of upper bits act in the same cycle. A signalling NaN is sent with merge_i set, and the bench expects the default NaN in the low element together with the first source in the upper bits. Invalid reporting and its routing also act in the same cycle. The bench alternates trap_en_i across invalid requests sent back to back. The scoreboard item for each request carries the expected trap pulse and the expected cumulative sticky flag, so a request routed to the wrong path shows up on the exact result where it occurred.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [1:0] {
    OP_MAX    = 2'b00,
    OP_MIN    = 2'b01,
    OP_MAXNUM = 2'b10,
    OP_MINNUM = 2'b11
  } fpmm_op_e;

  typedef enum logic [1:0] {
    FT_SINGLE = 2'b00,
    FT_DOUBLE = 2'b01,
    FT_RSVD   = 2'b10,
    FT_HALF   = 2'b11
  } fpmm_type_e;

  // format index: 0 half, 1 single, 2 double
  localparam int NUM_FMT = 3;
  localparam int ELEM_W  = 64;
  localparam int FMT_EXP_W [NUM_FMT] = '{5, 8, 11};
  localparam int FMT_MAN_W [NUM_FMT] = '{10, 23, 52};
endpackage

// File: rtl/fpmm_class.sv
module fpmm_class #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val_i,
  output logic         nan_o,
  output logic         snan_o,
  output logic [W-1:0] key_o
);
  assign nan_o  = (&val_i[W-2:MAN_W]) && (|val_i[MAN_W-1:0]);
  assign snan_o = nan_o && !val_i[MAN_W-1];
  // monotonic unsigned key; -0 maps just below +0
  assign key_o  = val_i[W-1] ? ~val_i : {1'b1, val_i[W-2:0]};
endmodule

// File: rtl/fpmm_core.sv
module fpmm_core
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fpmm_op_e     op_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o
);
  localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic         nan_a, nan_b, snan_a, snan_b;
  logic [W-1:0] key_a, key_b;

  fpmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .val_i(a_i), .nan_o(nan_a), .snan_o(snan_a), .key_o(key_a));
  fpmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .val_i(b_i), .nan_o(nan_b), .snan_o(snan_b), .key_o(key_b));

  logic want_max, num_pref, pick_b;
  assign want_max = (op_i == OP_MAX) || (op_i == OP_MAXNUM);
  assign num_pref = (op_i == OP_MAXNUM) || (op_i == OP_MINNUM);
  assign pick_b   = want_max ? (key_a < key_b) : (key_b < key_a);

  always_comb begin
    invalid_o = snan_a || snan_b;
    if (invalid_o)          res_o = DNAN;
    else if (nan_a && nan_b) res_o = DNAN;
    else if (nan_a)         res_o = num_pref ? b_i : DNAN;
    else if (nan_b)         res_o = num_pref ? a_i : DNAN;
    else                    res_o = pick_b ? b_i : a_i;
  end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int VREG_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        type_i,
  input  logic [1:0]        op_i,
  input  logic              merge_i,
  input  logic              half_en_i,
  input  logic              trap_en_i,
  input  logic [VREG_W-1:0] src1_i,
  input  logic [VREG_W-1:0] src2_i,
  output logic              valid_o,
  output logic [VREG_W-1:0] result_o,
  output logic              invalid_o,
  output logic              undef_o,
  output logic              trap_req_o,
  output logic              sticky_invalid_o
);
  logic [ELEM_W-1:0] fmt_res  [NUM_FMT];
  logic [ELEM_W-1:0] fmt_mask [NUM_FMT];
  logic              fmt_inv  [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int W = 1 + FMT_EXP_W[g] + FMT_MAN_W[g];
    logic [W-1:0] r;
    logic         inv;
    fpmm_core #(.EXP_W(FMT_EXP_W[g]), .MAN_W(FMT_MAN_W[g])) u_core (
      .a_i      (src1_i[W-1:0]),
      .b_i      (src2_i[W-1:0]),
      .op_i     (fpmm_op_e'(op_i)),
      .res_o    (r),
      .invalid_o(inv)
    );
    assign fmt_res[g]  = ELEM_W'(r);
    assign fmt_inv[g]  = inv;
    assign fmt_mask[g] = {ELEM_W{1'b1}} >> (ELEM_W - W);
  end

  logic [1:0]        sel;
  logic              undef_c, inv_c;
  logic [VREG_W-1:0] res_c, low_mask;

  always_comb begin
    undef_c = 1'b0;
    sel     = 2'd1;
    unique case (fpmm_type_e'(type_i))
      FT_SINGLE: sel = 2'd1;
      FT_DOUBLE: sel = 2'd2;
      FT_HALF: begin
        sel     = 2'd0;
        undef_c = !half_en_i;
      end
      default: undef_c = 1'b1;
    endcase
    low_mask = VREG_W'(fmt_mask[sel]);
    res_c    = (merge_i ? (src1_i & ~low_mask) : '0) | VREG_W'(fmt_res[sel]);
    inv_c    = fmt_inv[sel];
    if (undef_c) begin
      res_c = '0;
      inv_c = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o          <= 1'b0;
      result_o         <= '0;
      invalid_o        <= 1'b0;
      undef_o          <= 1'b0;
      trap_req_o       <= 1'b0;
      sticky_invalid_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      invalid_o  <= valid_i && inv_c;
      undef_o    <= valid_i && undef_c;
      trap_req_o <= valid_i && inv_c && trap_en_i;
      if (valid_i) result_o <= res_c;
      if (valid_i && inv_c && !trap_en_i) sticky_invalid_o <= 1'b1;
    end
  end

  assert_undef_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0 && !invalid_o && !trap_req_o));
  assert_trap_has_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> invalid_o);
  assert_sticky_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_invalid_o |=> sticky_invalid_o);
  assert_sticky_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_invalid_o) |-> (invalid_o && !trap_req_o));
  assert_flags_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o || undef_o) |-> valid_o);
endmodule

// File: tb/test_fpmm_unit.sv
module test_fpmm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   type_i = '0, op_i = '0;
  logic         merge_i = 1'b0, half_en_i = 1'b0, trap_en_i = 1'b0;
  logic [127:0] src1_i = '0, src2_i = '0;
  logic         valid_o, invalid_o, undef_o, trap_req_o, sticky_invalid_o;
  logic [127:0] result_o;

  always #5 clk = ~clk;

  fpmm_unit i_fpmm_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .type_i(type_i), .op_i(op_i),
    .merge_i(merge_i), .half_en_i(half_en_i), .trap_en_i(trap_en_i),
    .src1_i(src1_i), .src2_i(src2_i), .valid_o(valid_o), .result_o(result_o),
    .invalid_o(invalid_o), .undef_o(undef_o), .trap_req_o(trap_req_o),
    .sticky_invalid_o(sticky_invalid_o));

  typedef struct {
    logic [127:0] res;
    logic inv, und, trap, sticky;
    string tag;
  } item_t;

  item_t  sb[$];
  int     n_run = 0, n_fail = 0;
  logic   sticky_m = 1'b0;
  localparam logic [127:0] PAT1 = 128'hA5A5_1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A;
  localparam logic [127:0] PAT2 = 128'h3C3C_8765_4321_FEDC_BA98_7766_5544_3322;

  function automatic item_t model(input logic [1:0] ty, op, input logic m, tr, f16,
                                  input logic [127:0] s1, s2, input string tag);
    item_t it;
    int ew, mw, w;
    logic und;
    logic [63:0] mask, a, b, emax, qbit, dn, sbit, r;
    logic nan_a, nan_b, sn_a, sn_b, inv;
    longint ka, kb;
    it.tag = tag;
    und = 1'b0; ew = 8; mw = 23;
    case (ty)
      2'b00: begin ew = 8;  mw = 23; end
      2'b01: begin ew = 11; mw = 52; end
      2'b11: begin ew = 5;  mw = 10; und = !f16; end
      default: und = 1'b1;
    endcase
    if (und) begin
      it.res = '0; it.inv = 0; it.und = 1; it.trap = 0; it.sticky = sticky_m;
      return it;
    end
    w    = 1 + ew + mw;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    a    = s1[63:0] & mask;
    b    = s2[63:0] & mask;
    emax = (64'd1 << ew) - 1;
    qbit = 64'd1 << (mw - 1);
    sbit = 64'd1 << (w - 1);
    dn   = (emax << mw) | qbit;
    nan_a = (((a >> mw) & emax) == emax) && ((a & (qbit | (qbit - 1))) != 0);
    nan_b = (((b >> mw) & emax) == emax) && ((b & (qbit | (qbit - 1))) != 0);
    sn_a  = nan_a && ((a & qbit) == 0);
    sn_b  = nan_b && ((b & qbit) == 0);
    ka = ((a & sbit) != 0) ? -longint'(a & ~sbit) - 1 : longint'(a);
    kb = ((b & sbit) != 0) ? -longint'(b & ~sbit) - 1 : longint'(b);
    inv = sn_a || sn_b;
    if (inv)                 r = dn;
    else if (nan_a && nan_b) r = dn;
    else if (nan_a)          r = op[1] ? b : dn;
    else if (nan_b)          r = op[1] ? a : dn;
    else if (!op[0])         r = (ka >= kb) ? a : b;
    else                     r = (ka <= kb) ? a : b;
    it.res  = (m ? (s1 & ~{64'd0, mask}) : 128'd0) | {64'd0, r};
    it.inv  = inv;
    it.und  = 0;
    it.trap = inv && tr;
    sticky_m = sticky_m | (inv && !tr);
    it.sticky = sticky_m;
    return it;
  endfunction

  task automatic drive(input logic [1:0] ty, op, input logic m, tr,
                       input logic [63:0] a, b, input string tag);
    logic [127:0] s1, s2;
    s1 = {PAT1[127:64], a};
    s2 = {PAT2[127:64], b};
    // keep pattern bits above esize
    case (ty)
      2'b00: begin s1[63:32] = PAT1[63:32]; s2[63:32] = PAT2[63:32]; end
      2'b11, 2'b10: begin s1[63:16] = PAT1[63:16]; s2[63:16] = PAT2[63:16]; end
      default: ;
    endcase
    @(negedge clk);
    valid_i = 1'b1; type_i = ty; op_i = op; merge_i = m; trap_en_i = tr;
    src1_i = s1; src2_i = s2;
    sb.push_back(model(ty, op, m, tr, half_en_i, s1, s2, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        item_t e;
        n_run++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R9 %s: unexpected valid_o", "scoreboard");
        end else begin
          e = sb.pop_front();
          if (result_o !== e.res || invalid_o !== e.inv || undef_o !== e.und ||
              trap_req_o !== e.trap || sticky_invalid_o !== e.sticky) begin
            n_fail++;
            $display("FAIL %s: got res=%h inv=%b und=%b trap=%b sticky=%b exp res=%h inv=%b und=%b trap=%b sticky=%b",
                     e.tag, result_o, invalid_o, undef_o, trap_req_o, sticky_invalid_o,
                     e.res, e.inv, e.und, e.trap, e.sticky);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (valid_o !== 0 || result_o !== '0 || invalid_o !== 0 || undef_o !== 0 ||
        trap_req_o !== 0 || sticky_invalid_o !== 0) begin
      n_fail++;
      $display("FAIL R9 reset: got valid=%b res=%h flags=%b%b%b%b expected all zero",
               valid_o, result_o, invalid_o, undef_o, trap_req_o, sticky_invalid_o);
    end
    rst_n = 1'b1;
    // R1 R3 R4 single
    drive(2'b00, 2'b00, 1'b1, 1'b0, 64'h3F800000, 64'h40000000, "R1_R3 single max");
    drive(2'b00, 2'b01, 1'b0, 1'b0, 64'h3F800000, 64'h40000000, "R3 single min");
    drive(2'b00, 2'b00, 1'b0, 1'b0, 64'hBF800000, 64'h3F800000, "R4 sign order max");
    drive(2'b00, 2'b00, 1'b0, 1'b0, 64'h00000000, 64'h80000000, "R4 max(+0,-0)");
    drive(2'b00, 2'b01, 1'b0, 1'b0, 64'h00000000, 64'h80000000, "R4 min(+0,-0)");
    drive(2'b00, 2'b01, 1'b1, 1'b0, 64'hFF800000, 64'hBF800000, "R4 -inf min");
    drive(2'b00, 2'b00, 1'b0, 1'b0, 64'hC0000000, 64'hBF800000, "R4 negative magnitudes");
    drive(2'b00, 2'b00, 1'b0, 1'b0, 64'h7F800000, 64'h7F7FFFFF, "R4 +inf max");
    // R5 plain modes with NaN
    drive(2'b00, 2'b00, 1'b1, 1'b0, 64'h7FC00001, 64'h3F800000, "R5 qnan max");
    drive(2'b00, 2'b01, 1'b0, 1'b0, 64'h3F800000, 64'hFFC00000, "R5 qnan min");
    // R6 number preferring
    drive(2'b00, 2'b10, 1'b0, 1'b0, 64'h7FC00001, 64'hBF800000, "R6 maxnum qnan a");
    drive(2'b00, 2'b11, 1'b1, 1'b0, 64'h3F800000, 64'h7FC00002, "R6 minnum qnan b");
    drive(2'b00, 2'b10, 1'b0, 1'b0, 64'h7FC00001, 64'hFFC00003, "R6 maxnum both qnan");
    // R5 R7 R8: snan with merge, alternating routing
    drive(2'b00, 2'b00, 1'b1, 1'b1, 64'h7F800001, 64'h3F800000, "R5_R7_R8 snan trap");
    drive(2'b00, 2'b10, 1'b1, 1'b0, 64'h3F800000, 64'h7F800001, "R6_R8 snan sticky");
    drive(2'b00, 2'b11, 1'b0, 1'b1, 64'h7F800005, 64'h7FC00000, "R6_R8 snan trap after sticky");
    drive(2'b00, 2'b00, 1'b0, 1'b0, 64'h3F800000, 64'h40000000, "R8 sticky holds");
    // R1 double
    drive(2'b01, 2'b00, 1'b1, 1'b0, 64'h3FF0000000000000, 64'hC000000000000000, "R1 double max");
    drive(2'b01, 2'b01, 1'b0, 1'b0, 64'h3FF0000000000000, 64'hC000000000000000, "R1 double min");
    drive(2'b01, 2'b11, 1'b0, 1'b0, 64'h7FF8000000000001, 64'h3FF0000000000000, "R6 double minnum");
    drive(2'b01, 2'b00, 1'b0, 1'b1, 64'h7FF0000000000001, 64'h3FF0000000000000, "R5 double snan");
    // R1 R2 undefined encodings
    drive(2'b11, 2'b00, 1'b1, 1'b0, 64'h3C00, 64'h4000, "R1 half disabled undef");
    drive(2'b10, 2'b00, 1'b1, 1'b0, 64'h7C01, 64'h4000, "R2 type10 undef");
    idle();
    half_en_i = 1'b1;
    drive(2'b10, 2'b01, 1'b0, 1'b0, 64'h3C00, 64'h4000, "R2 type10 undef with half on");
    drive(2'b11, 2'b00, 1'b1, 1'b0, 64'h3C00, 64'h4000, "R1_R7 half max merge");
    drive(2'b11, 2'b01, 1'b0, 1'b0, 64'h3C00, 64'hC000, "R1 half min");
    drive(2'b11, 2'b10, 1'b1, 1'b0, 64'h7E01, 64'h4000, "R6 half maxnum");
    drive(2'b11, 2'b01, 1'b0, 1'b1, 64'h7C01, 64'h4000, "R5 half snan");
    idle();
    repeat (4) @(negedge clk);
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9 drain: got %0d pending expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule